// File: doc/BRIEF.md
# Display Vertical Frame Sequencer

This block produces the vertical half of a display frame. A horizontal timing block supplies a one-cycle line tick at the start of every line. Each tick starts the next line of the frame: the active lines, then the front porch, then the vertical sync interval, then the back porch, and then the cycle repeats.

The geometry comes from a 32-bit timing word. It holds the active line count and the sync width, both programmed as value-minus-one, and the two porches, which are direct counts. A mode input selects active panels, which get a frame-sync pulse, or passive panels, where the sync interval is only filled with blank inserted lines. The word and the mode are captured at the tick that starts each frame, so software may rewrite them at any time. For dual-panel use the line count is programmed per half-panel.

The outputs are registered and change only in the cycle after a tick. They describe the line that the most recent tick started: a vertical-active flag, the active line index, the frame sync level and a one-cycle frame-start pulse.

Top module: `vframe_seq`

## Requirements
- R1: Bits [9:0] of the timing word hold N-1, and each frame has N active lines. During these lines v_active_o is 1 and line_idx_o counts 0 to N-1, one step per tick.
- R2: Bits [15:10] hold S-1, and the sync interval lasts S lines.
- R3: Bits [23:16] hold F, the number of front-porch lines placed after the last active line. The value is a direct count from 0 to 255.
- R4: Bits [31:24] hold B, the number of back-porch lines placed after the last sync line and before the next frame's line 0. The value is a direct count from 0 to 255.
- R5: Lines follow the order active, front porch, sync, back porch, and the order repeats without gaps. A frame is N+F+S+B ticks long.
- R6: With passive_mode_i=0, frame_sync_o is 1 exactly on the S sync lines.
- R7: With passive_mode_i=1, frame_sync_o stays 0. The S sync-interval lines are still inserted, with v_active_o at 0.
- R8: A porch field of 0 removes that phase. The line after the last active line is then a sync line (F=0), or the line after the last sync line is active line 0 (B=0).
- R9: The timing word and the mode are sampled at the tick that starts active line 0. Changes at any later point in the frame do not affect the frame.
- R10: frame_start_o is 1 for exactly the one cycle after the tick that starts active line 0. v_active_o is then 1 and line_idx_o is 0.
- R11: line_idx_o is 0 on every line outside the active phase.
- R12: After reset all outputs are 0, and the first tick starts active line 0 of a frame.
- R13: The outputs change only in the cycle that follows a line tick. Otherwise they hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_tick_i | input | 1 | One-cycle pulse that starts a new line |
| timing_word_i | input | 32 | Vertical geometry word (fields in R1 to R4) |
| passive_mode_i | input | 1 | 1 = passive panel (no sync pulse), 0 = active panel |
| frame_sync_o | output | 1 | Vertical sync level, active high |
| v_active_o | output | 1 | Current line is an active line |
| line_idx_o | output | 10 | Index of the current active line, 0 outside the active phase |
| frame_start_o | output | 1 | One-cycle pulse when a frame's first line starts |

## Verification
The bench runs frames with every mix of porches: both present, both zero, only one present, and both at 255. These frames tell apart a correct phase skip from an off-by-one or a one-line minimum. It runs line counts of 1, 2, 4 and 1024 and sync widths of 1, 2, 3 and 64, which separate the minus-one fields from the direct counts. It alternates active and passive mode to show that passive frames keep the inserted sync lines but never raise the sync output. During each frame, after the first tick, the bench drives the inverted timing word and the opposite mode, which shows that the settings are held from the frame start.

// File: rtl/vframe_pkg.sv
package vframe_pkg;
  parameter int LINE_W  = 10;
  parameter int SYNC_W  = 6;
  parameter int PORCH_W = 8;
  parameter int WORD_W  = LINE_W + SYNC_W + 2 * PORCH_W;

  typedef enum logic [1:0] {
    PH_ACT   = 2'd0,
    PH_FRONT = 2'd1,
    PH_SYNC  = 2'd2,
    PH_BACK  = 2'd3
  } phase_e;

  typedef struct packed {
    logic [PORCH_W-1:0] back;
    logic [PORCH_W-1:0] front;
    logic [SYNC_W-1:0]  sync_m1;
    logic [LINE_W-1:0]  lines_m1;
  } vcfg_t;
endpackage

// File: rtl/vframe_field_unpack.sv
module vframe_field_unpack
  import vframe_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output vcfg_t             cfg_o
);
  localparam int SYNC_LSB  = LINE_W;
  localparam int FRONT_LSB = SYNC_LSB + SYNC_W;
  localparam int BACK_LSB  = FRONT_LSB + PORCH_W;

  always_comb begin
    cfg_o.lines_m1 = word_i[SYNC_LSB-1:0];
    cfg_o.sync_m1  = word_i[FRONT_LSB-1:SYNC_LSB];
    cfg_o.front    = word_i[BACK_LSB-1:FRONT_LSB];
    cfg_o.back     = word_i[BACK_LSB+PORCH_W-1:BACK_LSB];
  end
endmodule

// File: rtl/vframe_shadow.sv
module vframe_shadow
  import vframe_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  tick_i,
  input  logic  at_start_i,
  input  vcfg_t live_cfg_i,
  input  logic  live_passive_i,
  output vcfg_t cfg_o,
  output logic  passive_o
);
  vcfg_t cfg_q;
  logic  passive_q;
  logic  load;

  assign load = tick_i && at_start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q     <= '0;
      passive_q <= 1'b0;
    end else if (load) begin
      cfg_q     <= live_cfg_i;
      passive_q <= live_passive_i;
    end
  end

  // live values steer the tick that opens the frame, shadow the rest
  assign cfg_o     = at_start_i ? live_cfg_i : cfg_q;
  assign passive_o = at_start_i ? live_passive_i : passive_q;

  AST_SHADOW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load |=> $stable({cfg_q, passive_q})) // R9
    else $error("shadow changed without frame start");
endmodule

// File: rtl/vframe_walker.sv
module vframe_walker
  import vframe_pkg::*;
#(
  localparam int CNT_A = (LINE_W > PORCH_W) ? LINE_W : PORCH_W,
  localparam int CNT_W = (CNT_A > SYNC_W) ? CNT_A : SYNC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  vcfg_t            cfg_i,
  output phase_e           phase_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             at_start_o
);
  phase_e           ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, inc;

  assign inc = cnt_q + CNT_W'(1);

  always_comb begin
    ph_d  = ph_q;
    cnt_d = inc;
    unique case (ph_q)
      PH_ACT: if (cnt_q == CNT_W'(cfg_i.lines_m1)) begin
        cnt_d = '0;
        ph_d  = (cfg_i.front != '0) ? PH_FRONT : PH_SYNC;
      end
      PH_FRONT: if (inc == CNT_W'(cfg_i.front)) begin
        cnt_d = '0;
        ph_d  = PH_SYNC;
      end
      PH_SYNC: if (cnt_q == CNT_W'(cfg_i.sync_m1)) begin
        cnt_d = '0;
        ph_d  = (cfg_i.back != '0) ? PH_BACK : PH_ACT;
      end
      PH_BACK: if (inc == CNT_W'(cfg_i.back)) begin
        cnt_d = '0;
        ph_d  = PH_ACT;
      end
      default: begin
        cnt_d = '0;
        ph_d  = PH_ACT;
      end
    endcase
  end

  // state names the line the next tick will start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_ACT;
      cnt_q <= '0;
    end else if (tick_i) begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  assign phase_o    = ph_q;
  assign cnt_o      = cnt_q;
  assign at_start_o = (ph_q == PH_ACT) && (cnt_q == '0);

  AST_ACT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_ACT) |-> (cnt_q <= CNT_W'(cfg_i.lines_m1))) // R1
    else $error("active count past line limit");
  AST_FRONT_SKIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_FRONT) |-> (cnt_q < CNT_W'(cfg_i.front))) // R8
    else $error("front porch entered or overrun");
  AST_BACK_SKIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_BACK) |-> (cnt_q < CNT_W'(cfg_i.back))) // R8
    else $error("back porch entered or overrun");
  AST_SYNC_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_SYNC) |-> (cnt_q <= CNT_W'(cfg_i.sync_m1))) // R2
    else $error("sync count past width");
endmodule

// File: rtl/vframe_seq.sv
module vframe_seq
  import vframe_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_tick_i,
  input  logic [WORD_W-1:0] timing_word_i,
  input  logic              passive_mode_i,
  output logic              frame_sync_o,
  output logic              v_active_o,
  output logic [LINE_W-1:0] line_idx_o,
  output logic              frame_start_o
);
  localparam int CNT_A = (LINE_W > PORCH_W) ? LINE_W : PORCH_W;
  localparam int CNT_W = (CNT_A > SYNC_W) ? CNT_A : SYNC_W;

  vcfg_t            live_cfg, cfg;
  logic             passive, at_start;
  phase_e           phase;
  logic [CNT_W-1:0] cnt;

  vframe_field_unpack u_unpack (
    .word_i (timing_word_i),
    .cfg_o  (live_cfg)
  );

  vframe_shadow u_shadow (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .tick_i         (line_tick_i),
    .at_start_i     (at_start),
    .live_cfg_i     (live_cfg),
    .live_passive_i (passive_mode_i),
    .cfg_o          (cfg),
    .passive_o      (passive)
  );

  vframe_walker u_walker (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (line_tick_i),
    .cfg_i      (cfg),
    .phase_o    (phase),
    .cnt_o      (cnt),
    .at_start_o (at_start)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_sync_o  <= 1'b0;
      v_active_o    <= 1'b0;
      line_idx_o    <= '0;
      frame_start_o <= 1'b0;
    end else begin
      frame_start_o <= line_tick_i && at_start;
      if (line_tick_i) begin
        v_active_o   <= (phase == PH_ACT);
        line_idx_o   <= (phase == PH_ACT) ? cnt[LINE_W-1:0] : '0;
        frame_sync_o <= (phase == PH_SYNC) && !passive;
      end
    end
  end

  AST_SYNC_NOT_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_sync_o |-> !v_active_o) // R6
    else $error("sync during active line");
  AST_IDX_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !v_active_o |-> (line_idx_o == '0)) // R11
    else $error("index nonzero outside active");
  AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_tick_i |=> $stable({frame_sync_o, v_active_o, line_idx_o})) // R13
    else $error("outputs moved without tick");
  AST_START_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |=> !frame_start_o) // R10
    else $error("frame start wider than one cycle");
  AST_START_LINE0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> (v_active_o && line_idx_o == '0)) // R10
    else $error("frame start off line 0");
endmodule

// File: tb/vframe_seq_bench.sv
`timescale 1ns/1ps
module vframe_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [31:0] word = '0;
  logic        passive = 1'b0;
  logic        fsync, vact, fstart;
  logic [9:0]  idx;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  typedef struct {
    logic       act;
    logic [9:0] idx;
    logic       sync;
    logic       fs;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  vframe_seq u_vframe_seq (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .line_tick_i    (tick),
    .timing_word_i  (word),
    .passive_mode_i (passive),
    .frame_sync_o   (fsync),
    .v_active_o     (vact),
    .line_idx_o     (idx),
    .frame_start_o  (fstart)
  );

  function automatic logic [31:0] mk(int lines_m1, int sync_m1, int fp, int bp);
    return {bp[7:0], fp[7:0], sync_m1[5:0], lines_m1[9:0]};
  endfunction

  task automatic check(bit ok, string tag, string msg);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  task automatic push(logic a, int i, logic s, logic f, string t);
    exp_t e;
    e.act = a; e.idx = i[9:0]; e.sync = s; e.fs = f; e.tag = t;
    q.push_back(e);
  endtask

  task automatic line_tick();
    @(negedge clk) tick <= 1'b1;
    @(negedge clk) tick <= 1'b0;
    @(negedge clk);
  endtask

  // driver: expected lines come from the field values alone
  task automatic run_frame(int lines_m1, int sync_m1, int fp, int bp, bit pas);
    int total;
    for (int i = 0; i <= lines_m1; i++) push(1'b1, i, 1'b0, i == 0, "R1/R10");
    for (int i = 0; i < fp; i++)        push(1'b0, 0, 1'b0, 1'b0, "R3/R8");
    for (int i = 0; i <= sync_m1; i++)  push(1'b0, 0, !pas, 1'b0, pas ? "R7/R2" : "R6/R2");
    for (int i = 0; i < bp; i++)        push(1'b0, 0, 1'b0, 1'b0, "R4/R8");
    total = lines_m1 + 1 + fp + sync_m1 + 1 + bp;
    @(negedge clk);
    word    <= mk(lines_m1, sync_m1, fp, bp);
    passive <= pas;
    for (int l = 0; l < total; l++) begin
      line_tick();
      if (l == 0) begin
        word    <= ~mk(lines_m1, sync_m1, fp, bp); // R9: mid-frame change
        passive <= ~pas;
      end
    end
  endtask

  // monitor: pop one expected line per tick
  initial begin
    forever begin
      @(posedge clk);
      if (rst_n && tick) begin
        @(negedge clk);
        if (q.size() == 0) begin
          check(0, "R5", "unexpected line, queue empty");
        end else begin
          exp_t e;
          e = q.pop_front();
          check({vact, idx, fsync, fstart} === {e.act, e.idx, e.sync, e.fs}, e.tag,
                $sformatf("act/idx/sync/fs got %0b/%0d/%0b/%0b exp %0b/%0d/%0b/%0b",
                          vact, idx, fsync, fstart, e.act, e.idx, e.sync, e.fs));
          @(negedge clk);
          check(fstart === 1'b0, "R10",
                $sformatf("frame_start got %0b exp 0 one cycle later", fstart));
          check({vact, idx, fsync} === {e.act, e.idx, e.sync}, "R13",
                $sformatf("hold got %0b/%0d/%0b exp %0b/%0d/%0b",
                          vact, idx, fsync, e.act, e.idx, e.sync));
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n <= 1'b1;
    @(negedge clk);
    check({fsync, vact, idx, fstart} === 13'b0, "R12",
          $sformatf("reset outputs got %0b/%0b/%0d/%0b exp all 0", fsync, vact, idx, fstart));
    run_frame(3, 1, 2, 2, 1'b0);      // R1 R2 R3 R4 R6
    run_frame(3, 1, 2, 2, 1'b1);      // R7
    run_frame(1, 0, 0, 0, 1'b0);      // R8 both skipped
    run_frame(0, 2, 1, 0, 1'b1);      // R8 back skipped, single line
    run_frame(2, 0, 0, 3, 1'b0);      // R8 front skipped
    run_frame(1023, 63, 255, 255, 1'b0); // R1 R2 R3 R4 extremes
    run_frame(1, 1, 1, 1, 1'b0);      // R5 repeat after long frame
    repeat (4) @(negedge clk);
    check(q.size() == 0, "R5", $sformatf("lines left got %0d exp 0", q.size()));
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule